// File: doc/BRIEF.md
# Context-tagged translation lookaside buffer

This block is a small fully associative translation cache placed in front of a page-table walker. A requester presents a virtual address together with the address-space identifier of the running context. The block compares only the virtual page number against its entries and never stores or compares the offset bits. On a hit it returns the physical address one cycle later, built from the stored frame number and the offset of the request. On a miss it stalls the requester, hands the page number and identifier to an external walker, installs the mapping the walker returns and then completes the lookup. A walker fault installs nothing and is reported back as a fault.

Every entry carries an identifier tag and a global flag, so a context switch does not have to empty the whole array. A full flush drops every entry that is not global. A flush by identifier drops only the non-global entries of one context. Global entries, typically kernel mappings, answer a lookup from any context. A flush takes one cycle, and no lookup is accepted in that cycle.

Top module: `ctx_tlb`

## Requirements
- R1: After reset `rsp_valid` and `walk_req` are low, `req_ready` is high and every entry is invalid, so the first lookup of any page misses.
- R2: A request accepted (`req_valid` and `req_ready` high at a rising edge) that hits gives `rsp_valid` high after that edge with `rsp_fault` low and `rsp_paddr` = {stored frame number, `req_vaddr[11:0]`}; the offset of the request plays no part in matching.
- R3: An accepted request that misses raises `walk_req` after that edge with `walk_vpn` = `req_vaddr[31:12]` and `walk_asid` = `req_asid`, holds `req_ready` low until the walker answers, and after the edge where `walk_rsp_valid` is seen gives `rsp_valid` with `rsp_paddr` = {`walk_rsp_pfn`, request offset} and installs the mapping.
- R4: A non-global entry hits only when both its page number and its identifier equal those of the request.
- R5: An entry installed with `walk_rsp_global` = 1 hits for its page number whatever identifier is presented.
- R6: `flush_all` invalidates every non-global entry in one cycle; global entries stay resident.
- R7: `flush_by_id` invalidates only the non-global entries whose identifier equals `flush_id`; other identifiers and global entries stay resident. When both flush inputs are high, the full flush applies.
- R8: While a flush input is high `req_ready` is low and no request is accepted. A flush in the same cycle as a walker answer acts on the old content only: the mapping installed in that cycle stays valid.
- R9: A fill removes every valid entry that would answer the same lookup (same page number and either the same identifier or either side global), reusing the lowest-numbered such entry, so no lookup ever matches two entries.
- R10: A walker answer with `walk_rsp_fault` = 1 installs nothing and gives `rsp_valid` with `rsp_fault` = 1 and `rsp_paddr` = 0; a later lookup of that page misses again.
- R11: A fill with no entry to reuse takes the lowest-numbered invalid entry; when all entries are valid it takes the entry under a round-robin pointer that starts at entry 0 after reset and advances by one, wrapping, at each such replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_vaddr | input | 32 | Virtual address of the lookup |
| req_asid | input | 8 | Address-space identifier of the lookup |
| rsp_valid | output | 1 | Lookup result present for one cycle |
| rsp_paddr | output | 32 | Physical address of the result |
| rsp_fault | output | 1 | Result is a translation fault |
| walk_req | output | 1 | Walk requested, held until answered |
| walk_vpn | output | 20 | Page number to walk |
| walk_asid | output | 8 | Identifier of the walk |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_pfn | input | 20 | Frame number returned by the walker |
| walk_rsp_global | input | 1 | Returned mapping is global |
| walk_rsp_fault | input | 1 | Walker found no mapping |
| flush_all | input | 1 | Invalidate all non-global entries |
| flush_by_id | input | 1 | Invalidate non-global entries of one identifier |
| flush_id | input | 8 | Identifier for the selective flush |

## Verification
The two functions that can land in one cycle are a flush and the install of a walker answer, since a flush is allowed while a walk is pending. The bench raises `flush_all` in exactly the cycle it drives the walker answer, and then looks the same page up again from the same context: a hit with the walked frame shows that the flush acted on the old content and left the fresh entry valid. The same run also checks that the stalled request presented beside each flush is neither answered nor sent to the walker.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } tlb_state_e;
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry #(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  input  logic              fl_all,
  input  logic              fl_id_en,
  input  logic [ASID_W-1:0] fl_id,
  input  logic              wr_en,
  input  logic              drop_en,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_glb,
  output logic              same_key,
  output logic              valid,
  output logic [PFN_W-1:0]  pfn
);
  logic              vld_q, vld_d;
  logic              glb_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [ASID_W-1:0] asid_q;
  logic [PFN_W-1:0]  pfn_q;
  logic              flush_hit;

  always_comb begin
    lk_hit    = vld_q && (vpn_q == lk_vpn) && (glb_q || (asid_q == lk_asid));
    same_key  = vld_q && (vpn_q == wr_vpn) && (glb_q || wr_glb || (asid_q == wr_asid));
    flush_hit = vld_q && !glb_q && (fl_all || (fl_id_en && (asid_q == fl_id)));
    vld_d     = vld_q;
    if (flush_hit || drop_en) vld_d = 1'b0;
    if (wr_en)                vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q  <= 1'b0;
      vpn_q  <= '0;
      asid_q <= '0;
      pfn_q  <= '0;
    end else if (wr_en) begin
      glb_q  <= wr_glb;
      vpn_q  <= wr_vpn;
      asid_q <= wr_asid;
      pfn_q  <= wr_pfn;
    end
  end

  assign valid = vld_q;
  assign pfn   = pfn_q;

  // R6: a global entry outlives any flush
  assert_global_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && glb_q && !drop_en && (fl_all || fl_id_en)) |=> vld_q);

  // R7: a selective flush of this entry's identifier removes it unless refilled
  assert_id_flush_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !glb_q && fl_id_en && (asid_q == fl_id) && !wr_en) |=> !vld_q);
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     same_key,
  input  logic             fill,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] rr_q, rr_d;
  logic [IDX_W-1:0] key_idx, free_idx;
  logic             any_key, any_free, use_rr;

  always_comb begin
    key_idx  = '0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (same_key[i]) key_idx  = IDX_W'(i);
      if (!valid[i])   free_idx = IDX_W'(i);
    end
    any_key  = |same_key;
    any_free = !(&valid);
    use_rr   = !any_key && !any_free;
    if (any_key)       idx = key_idx;
    else if (any_free) idx = free_idx;
    else               idx = rr_q;
    rr_d = rr_q;
    if (fill && use_rr) rr_d = (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  // R11: a replacement in a full array moves the pointer by exactly one
  assert_rr_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fill && use_rr) |=> (rr_q == (($past(rr_q) == IDX_W'(N - 1)) ? '0 : $past(rr_q) + 1'b1)));

  // R11: with a free slot and nothing to reuse, the chosen slot is invalid
  assert_free_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fill && !any_key && any_free) |-> !valid[idx]);
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import ctx_tlb_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFS_W  = 12,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [ASID_W-1:0]     req_asid,
  output logic                  req_ready,
  input  logic                  flush_any,
  input  logic                  hit,
  input  logic [PFN_W-1:0]      hit_pfn,
  input  logic                  walk_rsp_valid,
  input  logic [PFN_W-1:0]      walk_rsp_pfn,
  input  logic                  walk_rsp_fault,
  output logic                  walk_req,
  output logic [VA_W-OFS_W-1:0] pend_vpn,
  output logic [ASID_W-1:0]     pend_asid,
  output logic                  fill_en,
  output logic                  rsp_valid,
  output logic [PFN_W+OFS_W-1:0] rsp_paddr,
  output logic                  rsp_fault
);
  localparam int PA_W = PFN_W + OFS_W;

  tlb_state_e        st_q, st_d;
  logic [VA_W-1:0]   pva_q;
  logic [ASID_W-1:0] pasid_q;
  logic              accept, walking, answered;
  logic              rv_d, rf_d;
  logic [PA_W-1:0]   rpa_d;
  logic              rv_q, rf_q;
  logic [PA_W-1:0]   rpa_q;

  always_comb begin
    walking   = (st_q == ST_WALK);
    req_ready = !walking && !flush_any;
    accept    = req_valid && req_ready;
    answered  = walking && walk_rsp_valid;
    fill_en   = answered && !walk_rsp_fault;

    st_d = st_q;
    case (st_q)
      ST_IDLE: if (accept && !hit) st_d = ST_WALK;
      ST_WALK: if (walk_rsp_valid) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase

    rv_d  = (accept && hit) || answered;
    rf_d  = rf_q;
    rpa_d = rpa_q;
    if (accept && hit) begin
      rf_d  = 1'b0;
      rpa_d = {hit_pfn, req_vaddr[OFS_W-1:0]};
    end else if (answered) begin
      rf_d  = walk_rsp_fault;
      rpa_d = walk_rsp_fault ? '0 : {walk_rsp_pfn, pva_q[OFS_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      rv_q <= 1'b0;
      rf_q <= 1'b0;
      rpa_q <= '0;
    end else begin
      st_q <= st_d;
      rv_q <= rv_d;
      rf_q <= rf_d;
      rpa_q <= rpa_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pva_q   <= '0;
      pasid_q <= '0;
    end else if (accept) begin
      pva_q   <= req_vaddr;
      pasid_q <= req_asid;
    end
  end

  assign walk_req  = walking;
  assign pend_vpn  = pva_q[VA_W-1:OFS_W];
  assign pend_asid = pasid_q;
  assign rsp_valid = rv_q;
  assign rsp_fault = rf_q;
  assign rsp_paddr = rpa_q;

  // R2: an accepted hit answers in the next cycle without fault
  assert_hit_answers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> (rsp_valid && !rsp_fault && !walk_req));

  // R3: an accepted miss starts a walk and blocks further requests
  assert_miss_walks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> (walk_req && !req_ready && !rsp_valid));

  // R3: the walker answer ends the walk and produces a result
  assert_walk_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && walk_rsp_valid) |=> (rsp_valid && !walk_req));

  // R8: no request is taken while a flush is applied
  assert_flush_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_any |-> !req_ready);

  // R10: a fault result carries a zero address
  assert_fault_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import ctx_tlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFS_W   = 12,
  parameter int ASID_W  = 8,
  parameter int ENTRIES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic [ASID_W-1:0]      req_asid,
  output logic                   rsp_valid,
  output logic [PA_W-1:0]        rsp_paddr,
  output logic                   rsp_fault,
  output logic                   walk_req,
  output logic [VA_W-OFS_W-1:0]  walk_vpn,
  output logic [ASID_W-1:0]      walk_asid,
  input  logic                   walk_rsp_valid,
  input  logic [PA_W-OFS_W-1:0]  walk_rsp_pfn,
  input  logic                   walk_rsp_global,
  input  logic                   walk_rsp_fault,
  input  logic                   flush_all,
  input  logic                   flush_by_id,
  input  logic [ASID_W-1:0]      flush_id
);
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PFN_W = PA_W - OFS_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] hit_vec, key_vec, vld_vec, wr_vec, drop_vec;
  logic [PFN_W-1:0]   pfn_arr [ENTRIES];
  logic [PFN_W-1:0]   hit_pfn;
  logic               hit, fill_en, flush_any;
  logic [IDX_W-1:0]   vic_idx;
  logic [VPN_W-1:0]   pend_vpn;
  logic [ASID_W-1:0]  pend_asid;

  assign flush_any = flush_all || flush_by_id;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      assign wr_vec[g]   = fill_en && (vic_idx == IDX_W'(g));
      assign drop_vec[g] = fill_en && key_vec[g] && (vic_idx != IDX_W'(g));

      tlb_entry #(
        .VPN_W  (VPN_W),
        .PFN_W  (PFN_W),
        .ASID_W (ASID_W)
      ) u_entry (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (req_vaddr[VA_W-1:OFS_W]),
        .lk_asid  (req_asid),
        .lk_hit   (hit_vec[g]),
        .fl_all   (flush_all),
        .fl_id_en (flush_by_id),
        .fl_id    (flush_id),
        .wr_en    (wr_vec[g]),
        .drop_en  (drop_vec[g]),
        .wr_vpn   (pend_vpn),
        .wr_asid  (pend_asid),
        .wr_pfn   (walk_rsp_pfn),
        .wr_glb   (walk_rsp_global),
        .same_key (key_vec[g]),
        .valid    (vld_vec[g]),
        .pfn      (pfn_arr[g])
      );
    end
  endgenerate

  always_comb begin
    hit_pfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_pfn = hit_pfn | pfn_arr[i];
    end
    hit = |hit_vec;
  end

  tlb_victim #(
    .N     (ENTRIES),
    .IDX_W (IDX_W)
  ) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (vld_vec),
    .same_key (key_vec),
    .fill     (fill_en),
    .idx      (vic_idx)
  );

  tlb_ctrl #(
    .VA_W   (VA_W),
    .OFS_W  (OFS_W),
    .ASID_W (ASID_W),
    .PFN_W  (PFN_W)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_vaddr      (req_vaddr),
    .req_asid       (req_asid),
    .req_ready      (req_ready),
    .flush_any      (flush_any),
    .hit            (hit),
    .hit_pfn        (hit_pfn),
    .walk_rsp_valid (walk_rsp_valid),
    .walk_rsp_pfn   (walk_rsp_pfn),
    .walk_rsp_fault (walk_rsp_fault),
    .walk_req       (walk_req),
    .pend_vpn       (pend_vpn),
    .pend_asid      (pend_asid),
    .fill_en        (fill_en),
    .rsp_valid      (rsp_valid),
    .rsp_paddr      (rsp_paddr),
    .rsp_fault      (rsp_fault)
  );

  assign walk_vpn  = pend_vpn;
  assign walk_asid = pend_asid;

  // R9: no lookup ever matches more than one entry
  assert_single_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R10: a faulting walker answer writes no entry
  assert_fault_no_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_rsp_valid && walk_rsp_fault) |-> (wr_vec == '0));
endmodule

// File: tb/tb_ctx_tlb.sv
module tb_ctx_tlb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr;
  logic [7:0]  req_asid;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        walk_req;
  logic [19:0] walk_vpn;
  logic [7:0]  walk_asid;
  logic        walk_rsp_valid, walk_rsp_global, walk_rsp_fault;
  logic [19:0] walk_rsp_pfn;
  logic        flush_all, flush_by_id;
  logic [7:0]  flush_id;

  int n_chk = 0;
  int n_bad = 0;
  logic [32:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  ctx_tlb dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a result appears
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected result", {31'h0, rsp_fault, rsp_paddr}, 64'h0);
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({rsp_fault, rsp_paddr} == e, t, {31'h0, rsp_fault, rsp_paddr}, {31'h0, e});
      end
    end
  end

  // driver: one lookup; pfn is the expected frame on a hit, the walker frame on a miss
  task automatic lookup(input logic [31:0] va, input logic [7:0] id, input bit miss,
                        input logic [19:0] pfn, input bit glb, input bit flt,
                        input bit fl_same, input string tag);
    @(negedge clk);
    req_vaddr = va;
    req_asid  = id;
    req_valid = 1'b1;
    exp_q.push_back((miss && flt) ? {1'b1, 32'h0} : {1'b0, pfn, va[11:0]});
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(walk_req == miss, {tag, " walk_req"}, {63'h0, walk_req}, {63'h0, miss});
    if (miss) begin
      chk(walk_vpn == va[31:12], {tag, " walk_vpn (R3)"}, {44'h0, walk_vpn}, {44'h0, va[31:12]});
      chk(walk_asid == id, {tag, " walk_asid (R3)"}, {56'h0, walk_asid}, {56'h0, id});
      chk(!req_ready, {tag, " ready low while walking (R3)"}, {63'h0, req_ready}, 64'h0);
      walk_rsp_valid  = 1'b1;
      walk_rsp_pfn    = pfn;
      walk_rsp_global = glb;
      walk_rsp_fault  = flt;
      flush_all       = fl_same;
      @(posedge clk);
      @(negedge clk);
      walk_rsp_valid = 1'b0;
      flush_all      = 1'b0;
    end
  endtask

  task automatic flush(input bit all, input bit by_id, input logic [7:0] id, input string tag);
    @(negedge clk);
    flush_all   = all;
    flush_by_id = by_id;
    flush_id    = id;
    req_vaddr   = 32'hDEAD_B000;
    req_asid    = 8'h01;
    req_valid   = 1'b1;
    #1;
    chk(!req_ready, {tag, " ready low in flush (R8)"}, {63'h0, req_ready}, 64'h0);
    @(posedge clk);
    @(negedge clk);
    flush_all   = 1'b0;
    flush_by_id = 1'b0;
    req_valid   = 1'b0;
    chk(!rsp_valid && !walk_req, {tag, " stalled request not taken (R8)"},
        {62'h0, rsp_valid, walk_req}, 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'h0, 64'h1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_vaddr = '0; req_asid = '0;
    walk_rsp_valid = 1'b0; walk_rsp_pfn = '0; walk_rsp_global = 1'b0; walk_rsp_fault = 1'b0;
    flush_all = 1'b0; flush_by_id = 1'b0; flush_id = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid, "R1 rsp_valid after reset", {63'h0, rsp_valid}, 64'h0);
    chk(!walk_req, "R1 walk_req after reset", {63'h0, walk_req}, 64'h0);
    chk(req_ready, "R1 req_ready after reset", {63'h0, req_ready}, 64'h1);

    lookup(32'h1234_5678, 8'h01, 1, 20'hAAAAA, 0, 0, 0, "R1 R3 first lookup misses");
    lookup(32'h1234_5ABC, 8'h01, 0, 20'hAAAAA, 0, 0, 0, "R2 hit with other offset");
    lookup(32'h1234_5000, 8'h02, 1, 20'hBBBBB, 0, 0, 0, "R4 other id misses");
    lookup(32'h1234_5010, 8'h01, 0, 20'hAAAAA, 0, 0, 0, "R4 id 1 hit");
    lookup(32'h1234_5010, 8'h02, 0, 20'hBBBBB, 0, 0, 0, "R4 id 2 hit");
    lookup(32'h0FFF_F123, 8'h05, 1, 20'hCCCCC, 1, 0, 0, "R5 global fill");
    lookup(32'h0FFF_F123, 8'h09, 0, 20'hCCCCC, 0, 0, 0, "R5 global hit other id");
    lookup(32'h5555_5444, 8'h01, 1, 20'h0, 0, 1, 0, "R10 fault result");
    lookup(32'h5555_5444, 8'h01, 1, 20'hDDDDD, 0, 0, 0, "R10 refetch after fault");
    lookup(32'h5555_5448, 8'h01, 0, 20'hDDDDD, 0, 0, 0, "R2 hit after fill");

    flush(0, 1, 8'h01, "R7 flush id 1");
    lookup(32'h1234_5020, 8'h02, 0, 20'hBBBBB, 0, 0, 0, "R7 other id survives");
    lookup(32'h0FFF_F020, 8'h01, 0, 20'hCCCCC, 0, 0, 0, "R7 global survives");
    lookup(32'h1234_5030, 8'h01, 1, 20'hA0A0A, 0, 0, 0, "R7 id 1 entry gone");
    lookup(32'h5555_5030, 8'h01, 1, 20'hD0D0D, 0, 0, 0, "R7 second id 1 entry gone");

    flush(1, 0, 8'h00, "R6 full flush");
    lookup(32'h0FFF_F040, 8'h03, 0, 20'hCCCCC, 0, 0, 0, "R6 global survives");
    lookup(32'h1234_5040, 8'h02, 1, 20'hB0B0B, 0, 0, 0, "R6 non-global gone");

    lookup(32'h7777_7001, 8'h04, 1, 20'hE0E0E, 0, 0, 1, "R8 fill with flush same cycle");
    lookup(32'h7777_7002, 8'h04, 0, 20'hE0E0E, 0, 0, 0, "R8 new entry kept");
    lookup(32'h1234_5050, 8'h02, 1, 20'hB1B1B, 0, 0, 0, "R8 old entry flushed");

    // entries now: 0 = 12345/id2, 1 = 77777/id4; fill a global 77777 from id 6
    lookup(32'h7777_7003, 8'h06, 1, 20'hF1F1F, 1, 0, 0, "R9 global fill over id entry");
    lookup(32'h7777_7004, 8'h04, 0, 20'hF1F1F, 0, 0, 0, "R9 old id 4 mapping replaced");

    // full flush leaves globals in slots 1 and 2; fill the other 14 slots
    flush(1, 0, 8'h00, "R6 flush before fill-up");
    for (int i = 0; i < 14; i++)
      lookup(32'h4000_0000 + (i << 12), 8'h07, 1, 20'h50000 + 20'(i), 0, 0, 0, "R11 fill-up");
    lookup(32'h4FFF_F000, 8'h07, 1, 20'h6FFFF, 0, 0, 0, "R11 replace slot 0");
    lookup(32'h4000_0000, 8'h07, 1, 20'h70000, 0, 0, 0, "R11 slot 0 was victim");
    lookup(32'h7777_7005, 8'h04, 1, 20'h71717, 0, 0, 0, "R11 slot 1 was next victim");
    lookup(32'h4000_1008, 8'h07, 0, 20'h50001, 0, 0, 0, "R11 slot 3 untouched");
    lookup(32'h4FFF_F00C, 8'h07, 0, 20'h6FFFF, 0, 0, 0, "R11 replacement entry hits");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "all expected results seen (R2 R3)", 64'(exp_q.size()), 64'h0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule